// File: doc/BRIEF.md
# Fork-Join Round Sequencer

This controller runs one processing round each time a single-cycle trigger pulse arrives while it is at rest. A round has two phases. First it fires two worker engines at once and holds their start lines until it sees both report busy. It then waits until both have dropped busy again. Only after that join does it fire a third, dependent worker. It waits for that worker to finish and then returns to rest.

Every launch is confirmed by watching the worker's busy line rise, so the controller does not depend on how many cycles a worker takes to react. Trigger pulses that arrive during a round are dropped and are not stored for later. A three-bit state code is exposed for debug.

The two parallel workers must both raise busy before either one drops it. If that does not happen, the fork launch state never exits.

Top module: `fj_sequencer`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next clock edge puts the controller at rest: `dbg_state` = 0 and all three start outputs low.
- R2: At rest (`dbg_state` = 0) the controller stays at rest while `tick` is low. A clock edge that samples `tick` high moves it to the fork launch state (`dbg_state` = 1).
- R3: In the fork launch state `start_a` and `start_b` are both high. The controller stays in this state until an edge samples `busy_a` and `busy_b` both high, and then moves to the join-wait state (`dbg_state` = 2).
- R4: In the join-wait state all start outputs are low. The controller stays while `busy_a` or `busy_b` is high, and moves to the tail launch state (`dbg_state` = 3) on the first edge that samples both low.
- R5: In the tail launch state `start_c` is high until an edge samples `busy_c` high. That edge moves the controller to the tail-wait state (`dbg_state` = 4), where `start_c` is low.
- R6: In the tail-wait state the controller stays while `busy_c` is high, and returns to rest on the first edge that samples `busy_c` low.
- R7: A `tick` sampled in any state other than rest has no effect, and it is not remembered: after the round ends the controller stays at rest.
- R8: `start_a` and `start_b` are high only in the fork launch state, and `start_c` only in the tail launch state. `start_c` is never high while `busy_a` or `busy_b` is high.
- R9: Each accepted `tick` produces exactly one assertion of `start_c`. A rejected `tick` produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Single-cycle round trigger |
| busy_a | input | 1 | Parallel worker A busy |
| busy_b | input | 1 | Parallel worker B busy |
| busy_c | input | 1 | Dependent worker C busy |
| start_a | output | 1 | Launch request to worker A |
| start_b | output | 1 | Launch request to worker B |
| start_c | output | 1 | Launch request to worker C |
| dbg_state | output | 3 | State code: 0 rest, 1 fork launch, 2 join wait, 3 tail launch, 4 tail wait |

## Verification
A directed pass drives the busy lines by hand to test each wait condition in isolation. It raises only one parallel busy line and checks that the launch state holds. It drops the two parallel busy lines one at a time, which separates a join on both from a join on either. It holds `busy_c` low to check that the tail launch state waits. It also pulses `tick` mid-round to show the pulse is neither acted on nor queued. A randomized pass attaches behavioural workers with varied start delays and run lengths, so the A and B finish order and the trigger spacing change from round to round. That pass counts launches of C against accepted triggers and watches for C starting under a live A or B.

// File: rtl/fj_pkg.sv
package fj_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_REST     = 3'd0,
        ST_FORK     = 3'd1,
        ST_JOIN     = 3'd2,
        ST_TAIL     = 3'd3,
        ST_TAILWAIT = 3'd4
    } fj_state_e;

    typedef struct packed {
        fj_state_e state;
    } fj_regs_t;

endpackage

// File: rtl/fj_join.sv
// Reduces a group of parallel busy lines into "all raised" and "all dropped".
module fj_join #(
    parameter int N_PAR = 2
) (
    input  logic [N_PAR-1:0] busy,
    output logic             all_up,
    output logic             all_down
);
    logic [N_PAR:0] up_chain;
    logic [N_PAR:0] dn_chain;

    assign up_chain[0] = 1'b1;
    assign dn_chain[0] = 1'b1;

    for (genvar i = 0; i < N_PAR; i++) begin : g_chain
        assign up_chain[i+1] = up_chain[i] &  busy[i];
        assign dn_chain[i+1] = dn_chain[i] & ~busy[i];
    end

    assign all_up   = up_chain[N_PAR];
    assign all_down = dn_chain[N_PAR];
endmodule

// File: rtl/fj_start_dec.sv
// Decodes the current state into launch requests.
module fj_start_dec
    import fj_pkg::*;
#(
    parameter int N_PAR = 2
) (
    input  fj_state_e        state,
    output logic [N_PAR-1:0] par_start,
    output logic             tail_start
);
    for (genvar i = 0; i < N_PAR; i++) begin : g_par
        assign par_start[i] = (state == ST_FORK);
    end

    assign tail_start = (state == ST_TAIL);
endmodule

// File: rtl/fj_sequencer.sv
module fj_sequencer
    import fj_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               busy_a,
    input  logic               busy_b,
    input  logic               busy_c,
    output logic               start_a,
    output logic               start_b,
    output logic               start_c,
    output logic [STATE_W-1:0] dbg_state
);
    localparam int N_PAR = 2;

    fj_regs_t         regs_d, regs_q;
    logic [N_PAR-1:0] par_busy;
    logic [N_PAR-1:0] par_start;
    logic             par_all_up;
    logic             par_all_down;
    logic             tail_start;

    assign par_busy = {busy_b, busy_a};

    fj_join #(.N_PAR(N_PAR)) u_join (
        .busy     (par_busy),
        .all_up   (par_all_up),
        .all_down (par_all_down)
    );

    fj_start_dec #(.N_PAR(N_PAR)) u_dec (
        .state      (regs_q.state),
        .par_start  (par_start),
        .tail_start (tail_start)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_REST:     if (tick)         regs_d.state = ST_FORK;
            ST_FORK:     if (par_all_up)   regs_d.state = ST_JOIN;
            ST_JOIN:     if (par_all_down) regs_d.state = ST_TAIL;
            ST_TAIL:     if (busy_c)       regs_d.state = ST_TAILWAIT;
            ST_TAILWAIT: if (!busy_c)      regs_d.state = ST_REST;
            default:                       regs_d.state = ST_REST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q.state <= ST_REST;
        else     regs_q <= regs_d;
    end

    assign start_a   = par_start[0];
    assign start_b   = par_start[1];
    assign start_c   = tail_start;
    assign dbg_state = regs_q.state;

    // R2: a trigger at rest opens the fork
    a_r2_tick_launch: assert property (@(posedge clk) disable iff (rst)
        (dbg_state == 3'd0 && tick) |=> (dbg_state == 3'd1));

    // R3: launch holds until both parallel workers show busy
    a_r3_fork_hold: assert property (@(posedge clk) disable iff (rst)
        (dbg_state == 3'd1 && !(busy_a && busy_b)) |=> (dbg_state == 3'd1 && start_a && start_b));

    // R4: join waits while any parallel worker runs
    a_r4_join_wait: assert property (@(posedge clk) disable iff (rst)
        (dbg_state == 3'd2 && (busy_a || busy_b)) |=> (dbg_state == 3'd2));

    // R5: tail launch confirmed by busy_c
    a_r5_tail_confirm: assert property (@(posedge clk) disable iff (rst)
        (start_c && busy_c) |=> (dbg_state == 3'd4 && !start_c));

    // R6: tail completion returns to rest
    a_r6_tail_done: assert property (@(posedge clk) disable iff (rst)
        (dbg_state == 3'd4 && !busy_c) |=> (dbg_state == 3'd0));

    // R8: at most one launch group active at a time, parallel starts move together
    a_r8_one_group: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_a, start_c}) && (start_a == start_b));
endmodule

// File: tb/fj_sequencer_test.sv
module fj_worker_model (
    input  logic clk,
    input  logic en,
    input  logic start,
    output logic busy
);
    int phase;
    int cnt;

    initial begin
        busy  = 1'b0;
        phase = 0;
        cnt   = 0;
    end

    always @(negedge clk) begin
        if (!en) begin
            busy  = 1'b0;
            phase = 0;
        end else begin
            case (phase)
                0: if (start) begin
                    cnt = int'($urandom_range(0, 2));
                    if (cnt == 0) begin
                        busy  = 1'b1;
                        cnt   = int'($urandom_range(3, 7));
                        phase = 2;
                    end else begin
                        phase = 1;
                    end
                end
                1: begin
                    cnt = cnt - 1;
                    if (cnt == 0) begin
                        busy  = 1'b1;
                        cnt   = int'($urandom_range(3, 7));
                        phase = 2;
                    end
                end
                default: begin
                    cnt = cnt - 1;
                    if (cnt == 0) begin
                        busy  = 1'b0;
                        phase = 0;
                    end
                end
            endcase
        end
    end
endmodule

module fj_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       manual = 1'b1;
    logic       m_busy_a = 1'b0, m_busy_b = 1'b0, m_busy_c = 1'b0;
    logic       w_busy_a, w_busy_b, w_busy_c;
    logic       busy_a, busy_b, busy_c;
    logic       start_a, start_b, start_c;
    logic [2:0] dbg_state;

    int total = 0;
    int bad = 0;
    int accepted = 0;
    int next_id = 0;
    int expect_id = 0;
    int cycles = 0;
    int queue_ids[$];
    logic prev_sc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign busy_a = manual ? m_busy_a : w_busy_a;
    assign busy_b = manual ? m_busy_b : w_busy_b;
    assign busy_c = manual ? m_busy_c : w_busy_c;

    fj_worker_model wa (.clk(clk), .en(!manual), .start(start_a), .busy(w_busy_a));
    fj_worker_model wb (.clk(clk), .en(!manual), .start(start_b), .busy(w_busy_b));
    fj_worker_model wc (.clk(clk), .en(!manual), .start(start_c), .busy(w_busy_c));

    fj_sequencer uut (
        .clk(clk), .rst(rst), .tick(tick),
        .busy_a(busy_a), .busy_b(busy_b), .busy_c(busy_c),
        .start_a(start_a), .start_b(start_b), .start_c(start_c),
        .dbg_state(dbg_state)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Driver: a one-cycle trigger; pushes an expected tail launch if accepted at rest.
    task automatic fire_tick();
        @(negedge clk);
        tick = 1'b1;
        if (dbg_state == 3'd0) begin
            queue_ids.push_back(next_id);
            next_id++;
            accepted++;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Monitor: every new start_c must match a queued accepted trigger (R9),
    // and start_c must never overlap a live parallel worker (R8).
    always @(negedge clk) begin
        if (rst) begin
            prev_sc = 1'b0;
        end else begin
            if (start_c) begin
                check(!(busy_a || busy_b), "R8 start_c with parallel busy",
                      int'({busy_a, busy_b}), 0);
            end
            if (start_c && !prev_sc) begin
                if (queue_ids.size() == 0) begin
                    check(1'b0, "R9 tail launch without accepted tick", 1, 0);
                end else begin
                    int got;
                    got = queue_ids.pop_front();
                    check(got == expect_id, "R9 tail launch order", got, expect_id);
                    expect_id++;
                end
            end
            prev_sc = start_c;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            summary_and_end();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(dbg_state == 3'd0, "R1 reset state", int'(dbg_state), 0);
        check({start_a, start_b, start_c} == 3'b000, "R1 reset starts",
              int'({start_a, start_b, start_c}), 0);
        rst = 1'b0;

        repeat (3) @(negedge clk);
        check(dbg_state == 3'd0, "R2 rest without tick", int'(dbg_state), 0);

        fire_tick();
        check(dbg_state == 3'd1, "R2 tick opens fork", int'(dbg_state), 1);
        check(start_a && start_b && !start_c, "R3 fork starts",
              int'({start_a, start_b, start_c}), 6);

        m_busy_a = 1'b1;
        fire_tick();
        check(dbg_state == 3'd1 && start_a && start_b, "R3 hold with only A busy / R7",
              int'(dbg_state), 1);

        m_busy_b = 1'b1;
        @(negedge clk);
        check(dbg_state == 3'd2, "R3 both busy -> join", int'(dbg_state), 2);
        check({start_a, start_b, start_c} == 3'b000, "R4 no starts in join",
              int'({start_a, start_b, start_c}), 0);

        m_busy_a = 1'b0;
        @(negedge clk);
        check(dbg_state == 3'd2, "R4 join waits for B", int'(dbg_state), 2);

        m_busy_b = 1'b0;
        @(negedge clk);
        check(dbg_state == 3'd3 && start_c, "R4 join done -> tail launch", int'(dbg_state), 3);

        fire_tick();
        check(dbg_state == 3'd3 && start_c, "R5 tail launch waits / R7",
              int'(dbg_state), 3);

        m_busy_c = 1'b1;
        @(negedge clk);
        check(dbg_state == 3'd4 && !start_c, "R5 busy_c confirms tail", int'(dbg_state), 4);
        @(negedge clk);
        check(dbg_state == 3'd4, "R6 waits while busy_c", int'(dbg_state), 4);

        m_busy_c = 1'b0;
        @(negedge clk);
        check(dbg_state == 3'd0, "R6 return to rest", int'(dbg_state), 0);

        repeat (5) @(negedge clk);
        check(dbg_state == 3'd0 && !start_a, "R7 mid-round ticks not queued",
              int'(dbg_state), 0);
        check(accepted == 1, "R7 only one tick accepted", accepted, 1);

        manual = 1'b0;
        for (int r = 0; r < 40; r++) begin
            repeat (int'($urandom_range(0, 8))) @(negedge clk);
            fire_tick();
        end
        for (int w = 0; w < 200 && dbg_state != 3'd0; w++) @(negedge clk);
        repeat (3) @(negedge clk);

        check(dbg_state == 3'd0, "R6 rest after random rounds", int'(dbg_state), 0);
        check(queue_ids.size() == 0, "R9 every accepted tick launched C",
              queue_ids.size(), 0);
        check(expect_id == accepted, "R9 launch count", expect_id, accepted);
        check(accepted > 5, "R2 random rounds accepted", accepted, 6);

        summary_and_end();
    end
endmodule